// File: doc/BRIEF.md
# AC-link Input Frame Receiver

This block deserializes the codec-to-controller serial stream of an AC97-style audio link. The stream carries one bit per bit-clock period, most significant bit first. A frame is 256 bits long: a 16-bit tag slot followed by twelve 20-bit slots. A rising frame-sync marks bit 0 of the tag slot. The block runs on the system clock. The falling edge of the bit clock reaches it as a one-cycle strobe, and the serial data and sync are sampled in that cycle.

From each frame the block reads three things. The first is the codec-ready flag at the head of the tag slot. The second is the echoed register index and the active-low slot-request flags in slot 1. The third is the 16-bit register read-back value in slot 2. Read-back data is delivered only when three conditions hold: the codec is ready, the tag marks slots 1 and 2 valid, and the echoed index equals the address of the read command still outstanding. The request flags are inverted into a per-slot "supply data next frame" vector, which the output-frame side uses and which is held until the next ready frame replaces it.

Top module: `ac_link_rx`

## Requirements
- R1: While `rst` is high at a clock edge, every output goes low after that edge: `codec_ready`, `slot_req`, `stat_data`, `rd_done` and `rd_pending`.
- R2: `codec_ready` takes the value of frame bit 0, which is bit 15 of the tag slot. It changes on the clock edge that ends the strobe cycle of frame bit 15, and at no other time.
- R3: A frame whose ready bit is 0 changes none of `slot_req`, `stat_data`, `rd_done` or `rd_pending`.
- R4: In a ready frame, slot 1 is frame bits 16..35 and its bits 11..2 are active-low requests for output slots 3..12, with bit 11 belonging to slot 3. `slot_req[k]` becomes the inverse of slot-1 bit (11-k) on the edge after the strobe of frame bit 35. The vector then holds until the same point of the next ready frame.
- R5: A read-back is accepted when five conditions hold together: the frame is ready, tag bit 14 (slot 1 valid) is 1, tag bit 13 (slot 2 valid) is 1, a read is pending, and slot-1 bits 18..12 equal the pending address. On acceptance, the edge after the strobe of frame bit 55 loads `stat_data` with slot-2 bits 19..4, raises `rd_done` for exactly one cycle and clears `rd_pending`. Slot-2 bits 3..0 are discarded.
- R6: An echoed index that differs from the pending address leaves `stat_data` unchanged, gives no `rd_done` pulse and keeps `rd_pending` high.
- R7: With no read pending, no status is accepted, whatever index arrives.
- R8: If either slot-valid tag bit (14 or 13) is 0, no status is accepted.
- R9: A one-cycle `cmd_rd_stb` loads `cmd_rd_addr` as the pending address and sets `rd_pending` on the next edge. It takes priority over an acceptance in the same cycle.
- R10: A rising sync (sampled high at a strobe after being sampled low at the previous strobe) restarts the count at bit 0 at any point. Slots left incomplete contribute nothing. Once bit 255 has been received, further bits are ignored until the next rising sync.
- R11: A frame with all request flags low (fixed-rate operation) sets every bit of `slot_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One-cycle strobe per bit-clock falling edge |
| sync_in | input | 1 | Frame sync, sampled at the strobe |
| sdata_in | input | 1 | Serial data from the codec, sampled at the strobe |
| cmd_rd_stb | input | 1 | Load a new outstanding read address |
| cmd_rd_addr | input | 7 | Register index of the read command |
| codec_ready | output | 1 | Codec ready flag of the latest tag slot |
| slot_req | output | 10 | Bit k set: output slot k+3 needs data next frame |
| stat_data | output | 16 | Last accepted register read-back value |
| rd_done | output | 1 | One-cycle pulse when read-back data is accepted |
| rd_pending | output | 1 | A read command awaits its matching status |

## Verification
A wrong bit count shows up first in `codec_ready`, which is latched 16 bits into the frame. Within the same frame, the request vector and the read-back word would then come from shifted bit fields, and the bench would see them diverge from its model on the very edge they update. A wrong address or pending flag shows up as a missing or extra `rd_done` pulse, and as `rd_pending` failing to fall, both at bit 55 of the first frame that carries the echoed index. A bad resynchronization shows up as status taken from a frame that had been cut short, or as bits after the frame end being read as a new frame. Either one is visible within a single frame.

// File: rtl/ac_rx_pkg.sv
package ac_rx_pkg;
  localparam int TAG_W     = 16;
  localparam int SLOT_W    = 20;
  localparam int NUM_SLOTS = 12;
  localparam int IDX_W     = 7;
  localparam int DATA_W    = 16;

  typedef struct packed {
    logic s1_ok;
    logic s2_ok;
  } tag_valid_t;
endpackage

// File: rtl/ac_rx_framer.sv
module ac_rx_framer #(
  parameter int FRAME_BITS = 256,
  parameter int POS_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_stb,
  input  logic             sync_in,
  output logic [POS_W-1:0] cur_pos,
  output logic             cur_vld
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

  logic             sync_q;
  logic             run_q;
  logic [POS_W-1:0] pos_q;
  logic             sync_rise;

  assign sync_rise = sync_in & ~sync_q;

  always_comb begin
    cur_pos = pos_q + 1'b1;
    cur_vld = 1'b0;
    if (bit_stb) begin
      if (sync_rise) begin
        cur_pos = '0;
        cur_vld = 1'b1;
      end else if (run_q && (pos_q != LAST_POS)) begin
        cur_vld = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 1'b0;
      run_q  <= 1'b0;
      pos_q  <= '0;
    end else if (bit_stb) begin
      sync_q <= sync_in;
      run_q  <= cur_vld;
      if (cur_vld) pos_q <= cur_pos;
    end
  end
endmodule

// File: rtl/ac_rx_deser.sv
module ac_rx_deser #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);
  logic [W-2:0] sh_q;

  assign word = {sh_q, din};

  always_ff @(posedge clk) begin
    if (rst)           sh_q <= '0;
    else if (shift_en) sh_q <= word[W-2:0];
  end
endmodule

// File: rtl/ac_rx_slots.sv
module ac_rx_slots
  import ac_rx_pkg::*;
#(
  parameter int TAG_LEN  = 16,
  parameter int SLOT_LEN = 20,
  parameter int NREQ     = 10,
  parameter int IDX_BITS = 7,
  parameter int DAT_BITS = 16,
  parameter int POS_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [POS_W-1:0]    cur_pos,
  input  logic                cur_vld,
  input  logic [SLOT_LEN-1:0] word,
  input  logic                cmd_rd_stb,
  input  logic [IDX_BITS-1:0] cmd_rd_addr,
  output logic                codec_ready,
  output logic [NREQ-1:0]     slot_req,
  output logic [DAT_BITS-1:0] stat_data,
  output logic                rd_done,
  output logic                rd_pending
);
  localparam logic [POS_W-1:0] TAG_END = POS_W'(TAG_LEN - 1);
  localparam logic [POS_W-1:0] S1_END  = POS_W'(TAG_LEN + SLOT_LEN - 1);
  localparam logic [POS_W-1:0] S2_END  = POS_W'(TAG_LEN + 2*SLOT_LEN - 1);
  localparam int IDX_MSB = SLOT_LEN - 2;
  localparam int REQ_MSB = IDX_MSB - IDX_BITS;

  logic                at_tag, at_s1, at_s2;
  tag_valid_t          tag_q;
  logic [IDX_BITS-1:0] idx_q;
  logic [IDX_BITS-1:0] rd_addr_q;
  logic [NREQ-1:0]     req_dec;
  logic                accept;
  logic                unused_bits;

  assign at_tag = cur_vld && (cur_pos == TAG_END);
  assign at_s1  = cur_vld && (cur_pos == S1_END);
  assign at_s2  = cur_vld && (cur_pos == S2_END);

  genvar k;
  generate
    for (k = 0; k < NREQ; k++) begin : g_req
      assign req_dec[k] = ~word[REQ_MSB - k];
    end
  endgenerate

  assign accept = at_s2 && codec_ready && tag_q.s1_ok && tag_q.s2_ok &&
                  rd_pending && (idx_q == rd_addr_q);

  assign unused_bits = ^word[REQ_MSB-NREQ:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      codec_ready <= 1'b0;
      tag_q       <= '0;
    end else if (at_tag) begin
      codec_ready <= word[TAG_LEN-1];
      tag_q.s1_ok <= word[TAG_LEN-2];
      tag_q.s2_ok <= word[TAG_LEN-3];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      slot_req <= '0;
    end else if (at_s1) begin
      idx_q <= word[IDX_MSB -: IDX_BITS];
      if (codec_ready) slot_req <= req_dec;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_data  <= '0;
      rd_done    <= 1'b0;
      rd_pending <= 1'b0;
      rd_addr_q  <= '0;
    end else begin
      rd_done <= accept;
      if (accept) stat_data <= word[SLOT_LEN-1 -: DAT_BITS];
      if (cmd_rd_stb) begin
        rd_pending <= 1'b1;
        rd_addr_q  <= cmd_rd_addr;
      end else if (accept) begin
        rd_pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ac_link_rx.sv
module ac_link_rx
  import ac_rx_pkg::*;
#(
  parameter int TAG_LEN  = ac_rx_pkg::TAG_W,
  parameter int SLOT_LEN = ac_rx_pkg::SLOT_W,
  parameter int NSLOTS   = ac_rx_pkg::NUM_SLOTS,
  parameter int IDX_BITS = ac_rx_pkg::IDX_W,
  parameter int DAT_BITS = ac_rx_pkg::DATA_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_stb,
  input  logic                sync_in,
  input  logic                sdata_in,
  input  logic                cmd_rd_stb,
  input  logic [IDX_BITS-1:0] cmd_rd_addr,
  output logic                codec_ready,
  output logic [NSLOTS-3:0]   slot_req,
  output logic [DAT_BITS-1:0] stat_data,
  output logic                rd_done,
  output logic                rd_pending
);
  localparam int FRAME_BITS = TAG_LEN + NSLOTS * SLOT_LEN;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int NREQ       = NSLOTS - 2;

  logic [POS_W-1:0]    cur_pos;
  logic                cur_vld;
  logic [SLOT_LEN-1:0] word;

  ac_rx_framer #(.FRAME_BITS(FRAME_BITS), .POS_W(POS_W)) u_framer (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .sync_in(sync_in),
    .cur_pos(cur_pos), .cur_vld(cur_vld)
  );

  ac_rx_deser #(.W(SLOT_LEN)) u_deser (
    .clk(clk), .rst(rst), .shift_en(bit_stb), .din(sdata_in), .word(word)
  );

  ac_rx_slots #(
    .TAG_LEN(TAG_LEN), .SLOT_LEN(SLOT_LEN), .NREQ(NREQ),
    .IDX_BITS(IDX_BITS), .DAT_BITS(DAT_BITS), .POS_W(POS_W)
  ) u_slots (
    .clk(clk), .rst(rst), .cur_pos(cur_pos), .cur_vld(cur_vld), .word(word),
    .cmd_rd_stb(cmd_rd_stb), .cmd_rd_addr(cmd_rd_addr),
    .codec_ready(codec_ready), .slot_req(slot_req), .stat_data(stat_data),
    .rd_done(rd_done), .rd_pending(rd_pending)
  );
endmodule

// File: rtl/ac_link_rx_chk.sv
module ac_link_rx_chk #(
  parameter int NREQ     = 10,
  parameter int DAT_BITS = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                bit_stb,
  input logic                cmd_rd_stb,
  input logic                codec_ready,
  input logic [NREQ-1:0]     slot_req,
  input logic [DAT_BITS-1:0] stat_data,
  input logic                rd_done,
  input logic                rd_pending
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!codec_ready && slot_req == '0 && stat_data == '0 && !rd_done && !rd_pending));

  assert_ready_only_on_bit_R2: assert property (@(posedge clk) disable iff (rst)
    !bit_stb |=> $stable(codec_ready));

  assert_done_needs_ready_R3: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> codec_ready);

  assert_req_only_on_bit_R4: assert property (@(posedge clk) disable iff (rst)
    !bit_stb |=> $stable(slot_req));

  assert_data_moves_with_done_R5: assert property (@(posedge clk) disable iff (rst)
    !rd_done |-> $stable(stat_data));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> !rd_done);

  assert_done_clears_pending_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_done && !$past(cmd_rd_stb)) |-> !rd_pending);

  assert_done_needs_pending_R7: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> $past(rd_pending));

  assert_cmd_sets_pending_R9: assert property (@(posedge clk) disable iff (rst)
    cmd_rd_stb |=> rd_pending);
endmodule

bind ac_link_rx ac_link_rx_chk #(.NREQ(NSLOTS - 2), .DAT_BITS(DAT_BITS)) u_chk (
  .clk(clk), .rst(rst), .bit_stb(bit_stb), .cmd_rd_stb(cmd_rd_stb),
  .codec_ready(codec_ready), .slot_req(slot_req), .stat_data(stat_data),
  .rd_done(rd_done), .rd_pending(rd_pending)
);

// File: tb/test_ac_link_rx.sv
`timescale 1ns/1ps
module test_ac_link_rx;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1;
  logic        bit_stb = 1'b0, sync_in = 1'b0, sdata_in = 1'b0;
  logic        cmd_rd_stb = 1'b0;
  logic [6:0]  cmd_rd_addr = '0;
  logic        codec_ready, rd_done, rd_pending;
  logic [9:0]  slot_req;
  logic [15:0] stat_data;

  ac_link_rx i_ac_link_rx (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .sync_in(sync_in), .sdata_in(sdata_in),
    .cmd_rd_stb(cmd_rd_stb), .cmd_rd_addr(cmd_rd_addr),
    .codec_ready(codec_ready), .slot_req(slot_req), .stat_data(stat_data),
    .rd_done(rd_done), .rd_pending(rd_pending)
  );

  int vectors = 0, miscompares = 0, done_cnt = 0;
  bit started = 1'b0;

  // behavioural reference
  int          m_pos = -1;
  logic        m_sprev = 1'b0;
  logic        fb [0:255];
  logic        m_ready = 1'b0, m_v1 = 1'b0, m_v2 = 1'b0, m_done = 1'b0, m_pend = 1'b0;
  logic [9:0]  m_req = '0;
  logic [15:0] m_data = '0;
  logic [6:0]  m_addr = '0;

  always @(posedge clk) begin : ref_model
    logic       rise;
    logic [6:0] idx;
    if (rst) begin
      m_pos = -1; m_sprev = 1'b0; m_ready = 1'b0; m_v1 = 1'b0; m_v2 = 1'b0;
      m_done = 1'b0; m_pend = 1'b0; m_req = '0; m_data = '0; m_addr = '0;
    end else begin
      m_done = 1'b0;
      if (bit_stb) begin
        rise = sync_in && !m_sprev;
        m_sprev = sync_in;
        if (rise) m_pos = 0;
        else if (m_pos >= 0 && m_pos < 255) m_pos = m_pos + 1;
        else m_pos = -1;
        if (m_pos >= 0) begin
          fb[m_pos] = sdata_in;
          if (m_pos == 15) begin m_ready = fb[0]; m_v1 = fb[1]; m_v2 = fb[2]; end
          if (m_pos == 35 && m_ready)
            for (int k = 0; k < 10; k++) m_req[k] = !fb[24+k];
          if (m_pos == 55) begin
            idx = '0;
            for (int j = 0; j < 7; j++) idx = {idx[5:0], fb[17+j]};
            if (m_ready && m_v1 && m_v2 && m_pend && idx == m_addr) begin
              for (int j = 0; j < 16; j++) m_data = {m_data[14:0], fb[36+j]};
              m_done = 1'b1;
              m_pend = 1'b0;
            end
          end
        end
      end
      if (cmd_rd_stb) begin m_addr = cmd_rd_addr; m_pend = 1'b1; end
    end
    started = 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("R2 codec_ready", 32'(codec_ready), 32'(m_ready));
      chk("R4 slot_req",    32'(slot_req),    32'(m_req));
      chk("R5 stat_data",   32'(stat_data),   32'(m_data));
      chk("R5 rd_done",     32'(rd_done),     32'(m_done));
      chk("R9 rd_pending",  32'(rd_pending),  32'(m_pend));
      if (rd_done === 1'b1) done_cnt++;
    end
  end

  function automatic logic [255:0] mk(input logic rdy, input logic v1, input logic v2,
                                      input logic [6:0] idx, input logic [9:0] req,
                                      input logic [15:0] dat);
    logic [255:0] f;
    f = {10{20'h5A5A5}} | 256'h0;
    f[255] = rdy; f[254] = v1; f[253] = v2;
    f[252:240] = 13'h0A5C;
    f[239:220] = {1'b0, idx, req, 2'b00};
    f[219:200] = {dat, 4'hA};
    return f;
  endfunction

  function automatic logic [9:0] exp_req(input logic [9:0] raw);
    logic [9:0] r;
    for (int k = 0; k < 10; k++) r[k] = ~raw[9-k];
    return r;
  endfunction

  task automatic send_bit(input logic b, input logic s);
    sdata_in = b; sync_in = s; bit_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_frame(input logic [255:0] f, input int nbits, input bit with_sync);
    for (int i = 0; i < nbits; i++) send_bit(f[255-i], with_sync && (i < 16));
  endtask

  task automatic issue_read(input logic [6:0] a);
    cmd_rd_addr = a; cmd_rd_stb = 1'b1;
    @(negedge clk);
    cmd_rd_stb = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    finish_run();
  end

  initial begin : stim
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 codec_ready", 32'(codec_ready), 0);
    chk("R1 slot_req",    32'(slot_req),    0);
    chk("R1 stat_data",   32'(stat_data),   0);
    chk("R1 rd_done",     32'(rd_done),     0);
    chk("R1 rd_pending",  32'(rd_pending),  0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R3: not-ready frame leaves requests alone
    send_frame(mk(1'b0, 1'b1, 1'b1, 7'h00, 10'h000, 16'h0000), 256, 1'b1);
    chk("R3 slot_req not ready", 32'(slot_req), 0);
    chk("R2 codec_ready low", 32'(codec_ready), 0);

    // R11 fixed-rate, R7 nothing pending
    send_frame(mk(1'b1, 1'b1, 1'b1, 7'h00, 10'h000, 16'h7777), 256, 1'b1);
    chk("R11 all requested", 32'(slot_req), 32'h3FF);
    chk("R2 codec_ready high", 32'(codec_ready), 1);
    chk("R7 no accept", 32'(stat_data), 0);
    chk("R7 no done", done_cnt, 0);

    // R9 / R5 matching read
    issue_read(7'h25);
    chk("R9 pending set", 32'(rd_pending), 1);
    send_frame(mk(1'b1, 1'b1, 1'b1, 7'h25, 10'b0011001010, 16'hBEEF), 256, 1'b1);
    chk("R5 data", 32'(stat_data), 32'hBEEF);
    chk("R5 done count", done_cnt, 1);
    chk("R5 pending cleared", 32'(rd_pending), 0);
    chk("R4 decode", 32'(slot_req), 32'(exp_req(10'b0011001010)));

    // R6 mismatch
    issue_read(7'h11);
    send_frame(mk(1'b1, 1'b1, 1'b1, 7'h12, 10'h0F0, 16'h1234), 256, 1'b1);
    chk("R6 data kept", 32'(stat_data), 32'hBEEF);
    chk("R6 pending kept", 32'(rd_pending), 1);
    chk("R6 no done", done_cnt, 1);

    // R8 invalid tag bits
    send_frame(mk(1'b1, 1'b1, 1'b0, 7'h11, 10'h0F0, 16'h1234), 256, 1'b1);
    chk("R8 slot2 invalid", 32'(stat_data), 32'hBEEF);
    send_frame(mk(1'b1, 1'b0, 1'b1, 7'h11, 10'h0F0, 16'h1234), 256, 1'b1);
    chk("R8 slot1 invalid", 32'(stat_data), 32'hBEEF);
    chk("R8 pending kept", 32'(rd_pending), 1);

    // R3 not-ready frame with matching content
    send_frame(mk(1'b0, 1'b1, 1'b1, 7'h11, 10'h155, 16'h1234), 256, 1'b1);
    chk("R3 data kept", 32'(stat_data), 32'hBEEF);
    chk("R3 req kept", 32'(slot_req), 32'(exp_req(10'h0F0)));
    chk("R3 pending kept", 32'(rd_pending), 1);
    chk("R2 not ready", 32'(codec_ready), 0);

    // R5 / R4 second accept
    send_frame(mk(1'b1, 1'b1, 1'b1, 7'h11, 10'h2C3, 16'h1234), 256, 1'b1);
    chk("R5 data 2", 32'(stat_data), 32'h1234);
    chk("R5 done count 2", done_cnt, 2);
    chk("R4 decode 2", 32'(slot_req), 32'(exp_req(10'h2C3)));

    // R10 resync mid-frame discards the partial slot 2
    issue_read(7'h33);
    send_frame(mk(1'b1, 1'b1, 1'b1, 7'h33, 10'h000, 16'hAAAA), 50, 1'b1);
    chk("R10 partial dropped", 32'(stat_data), 32'h1234);
    send_frame(mk(1'b1, 1'b1, 1'b1, 7'h33, 10'h3FF, 16'h5555), 256, 1'b1);
    chk("R10 resync data", 32'(stat_data), 32'h5555);
    chk("R10 resync req", 32'(slot_req), 0);
    chk("R10 done count", done_cnt, 3);

    // R10 bits after the frame end without sync are ignored
    issue_read(7'h44);
    send_frame(mk(1'b1, 1'b1, 1'b1, 7'h44, 10'h000, 16'h9999), 80, 1'b0);
    chk("R10 tail data", 32'(stat_data), 32'h5555);
    chk("R10 tail req", 32'(slot_req), 0);
    chk("R10 tail pending", 32'(rd_pending), 1);
    chk("R10 tail done", done_cnt, 3);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule